// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the feedback-divider value (M), the post-divider value (N) and a test-select code for a frequency synthesizer. Two paths can update them. The first is a parallel port with M and N data lines and a strobe. While the strobe is low, the port's values pass straight through to the active registers. The rising edge of the strobe freezes them. The second is a serial port with a serial clock, a data line and a commit strobe. It fills a shift register, and a falling edge on the commit strobe copies the register into the active values. The serial path works only while the parallel strobe is high.

All port pins are treated as asynchronous to the block clock. Each pin passes through a synchronizer of configurable depth. Edges of the serial clock and the two strobes are detected on the block clock. The serial data and the parallel data pass through a synchronizer of the same depth, so they stay aligned with the strobes. The reset input asserts asynchronously and is released on the clock.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is asserted, and after it is released with all inputs at zero, the M, N and test-select outputs are all zero.
- R2: While the parallel strobe is low, the M and N outputs follow the M and N inputs within the synchronizer delay plus one clock.
- R3: On a rising edge of the parallel strobe, the M and N values present at that edge are captured. Later changes on the M and N inputs have no effect while the strobe stays high.
- R4: A rising edge of the serial clock shifts the serial data bit into the LSB of a 12-bit shift register, but only while the parallel strobe is high. Serial clock edges while the strobe is low leave the shift register unchanged.
- R5: The stream carries the test field first, then N, then M, each field MSB first. After 12 shifts, shift register bits [11:9] hold the test field, bits [8:7] hold N and bits [6:0] hold M.
- R6: A falling edge of the commit strobe while the parallel strobe is high copies the shift register fields into the active test, N and M outputs. A rising edge or a steady level of the commit strobe changes nothing.
- R7: The test-select output reads 000 whenever the parallel strobe is low. No parallel input can set it.
- R8: A commit leaves the shift register contents unchanged, so a second commit with no shifting in between gives the same outputs again.
- R9: A commit after fewer than 12 shifts copies the register as it stands: the earlier contents moved up by the number of new bits, with the new bits at the bottom. No error is flagged.
- R10: A falling edge of the commit strobe while the parallel strobe is low has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pload_i | input | 1 | Parallel strobe: low means transparent, a rising edge captures |
| m_i | input | 7 | Parallel M value |
| n_i | input | 2 | Parallel N value |
| sclk_i | input | 1 | Serial clock; rising edge samples the data line |
| sdata_i | input | 1 | Serial data line |
| sload_i | input | 1 | Commit strobe; a falling edge transfers the shift register |
| m_o | output | 7 | Active M divider value |
| n_o | output | 2 | Active N divider value |
| test_o | output | 3 | Active test-select code |

## Verification
The bench builds the block with its default widths: a 7-bit M, a 2-bit N, a 3-bit test field and two synchronizer stages. This makes the full 12-bit stream, with its field boundaries at bits 9 and 7, directly observable. Every pin is held for several block clocks, so the two-stage synchronizer delay is covered. This also lets the bench create the conflict cases: serial traffic while the parallel strobe is low, commits that follow a short stream, and a commit repeated with no shifting in between.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int unsigned DEF_M_W     = 7;
  localparam int unsigned DEF_N_W     = 2;
  localparam int unsigned DEF_T_W     = 3;
  localparam int unsigned DEF_SYNC_ST = 2;

  // bit positions of the control pins inside the synchronized control vector
  typedef enum int unsigned {
    CTL_PLOAD = 0,
    CTL_SCLK  = 1,
    CTL_SLOAD = 2
  } ctl_idx_e;

  localparam int unsigned CTL_W = 3;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned SR_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q, sr_d;
  logic            sr_en;

  assign sr_en = enable_i & shift_i;

  always_comb begin
    sr_d = {sr_q[SR_W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr_o = sr_q;

  AST_SHIFT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(sr_q)); // R4

  AST_SHIFT_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && shift_i) |=> (sr_q[0] == $past(bit_i))); // R4
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int unsigned M_W     = DEF_M_W,
  parameter int unsigned N_W     = DEF_N_W,
  parameter int unsigned T_W     = DEF_T_W,
  parameter int unsigned SYNC_ST = DEF_SYNC_ST
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pload_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sload_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] test_o
);
  localparam int unsigned SR_W   = T_W + N_W + M_W;
  localparam int unsigned DATA_W = M_W + N_W + 1;
  localparam int unsigned M_LO   = 0;
  localparam int unsigned N_LO   = M_W;
  localparam int unsigned T_LO   = M_W + N_W;

  // reset: asynchronous assertion, release aligned to the clock
  logic [1:0] rst_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  // pin synchronizers, control and data with equal depth to stay aligned
  logic [CTL_W-1:0]  ctl_async, ctl_lvl;
  logic [CTL_W-1:0]  ctl_prv;
  logic [DATA_W-1:0] dat_async, dat_lvl;

  always_comb begin
    ctl_async            = '0;
    ctl_async[CTL_PLOAD] = pload_i;
    ctl_async[CTL_SCLK]  = sclk_i;
    ctl_async[CTL_SLOAD] = sload_i;
  end
  assign dat_async = {sdata_i, n_i, m_i};

  cfg_pin_sync #(.WIDTH(CTL_W), .STAGES(SYNC_ST)) u_ctl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .async_i(ctl_async),
    .sync_o (ctl_lvl)
  );

  cfg_pin_sync #(.WIDTH(DATA_W), .STAGES(SYNC_ST)) u_dat_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .async_i(dat_async),
    .sync_o (dat_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctl_prv <= '0;
    else        ctl_prv <= ctl_lvl;
  end

  logic           pl_lvl, pl_prv;
  logic           sclk_rise, sload_fall;
  logic [M_W-1:0] m_sync;
  logic [N_W-1:0] n_sync;
  logic           sd_sync;

  assign pl_lvl     = ctl_lvl[CTL_PLOAD];
  assign pl_prv     = ctl_prv[CTL_PLOAD];
  assign sclk_rise  = ctl_lvl[CTL_SCLK] & ~ctl_prv[CTL_SCLK];
  assign sload_fall = ~ctl_lvl[CTL_SLOAD] & ctl_prv[CTL_SLOAD];
  assign m_sync     = dat_lvl[M_W-1:0];
  assign n_sync     = dat_lvl[M_W +: N_W];
  assign sd_sync    = dat_lvl[DATA_W-1];

  // serial shift register
  logic [SR_W-1:0] sr;

  cfg_shifter #(.SR_W(SR_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .enable_i(pl_lvl),
    .shift_i (sclk_rise),
    .bit_i   (sd_sync),
    .sr_o    (sr)
  );

  // active register next state
  logic           commit, par_en, act_en;
  logic [M_W-1:0] m_q, m_d;
  logic [N_W-1:0] n_q, n_d;
  logic [T_W-1:0] t_q, t_d;

  assign commit = sload_fall & pl_lvl;
  assign par_en = ~(pl_lvl & pl_prv);   // low level, or the capturing rise
  assign act_en = commit | par_en;

  always_comb begin
    m_d = m_q;
    n_d = n_q;
    t_d = t_q;
    if (commit) begin
      m_d = sr[M_LO +: M_W];
      n_d = sr[N_LO +: N_W];
      t_d = sr[T_LO +: T_W];
    end else if (par_en) begin
      m_d = m_sync;
      n_d = n_sync;
      t_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (act_en) begin
      m_q <= m_d;
      n_q <= n_d;
      t_q <= t_d;
    end
  end

  assign m_o    = m_q;
  assign n_o    = n_q;
  assign test_o = t_q;

  AST_TEST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pl_lvl |=> (test_o == '0)); // R7

  AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_n)
    !pl_lvl |=> (m_o == $past(m_sync) && n_o == $past(n_sync))); // R2

  AST_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pl_lvl && pl_prv && !sload_fall) |=> ($stable(m_o) && $stable(n_o) && $stable(test_o))); // R3

  AST_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_n)
    commit |=> (m_o == $past(sr[M_LO +: M_W]) && n_o == $past(sr[N_LO +: N_W])
                && test_o == $past(sr[T_LO +: T_W]))); // R6

  AST_SR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (commit && !sclk_rise) |=> $stable(sr)); // R8
endmodule

// File: tb/synth_cfg_loader_tb.sv
module synth_cfg_loader_tb;
  localparam int SETTLE = 6;
  localparam int HOLD   = 3;

  typedef struct packed {
    logic [2:0] t;
    logic [1:0] n;
    logic [6:0] m;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       pload_i, sclk_i, sdata_i, sload_i;
  logic [6:0] m_i, m_o;
  logic [1:0] n_i, n_o;
  logic [2:0] test_o;

  always #5 clk_i = ~clk_i;

  synth_cfg_loader u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pload_i(pload_i), .m_i(m_i), .n_i(n_i),
    .sclk_i(sclk_i), .sdata_i(sdata_i), .sload_i(sload_i),
    .m_o(m_o), .n_o(n_o), .test_o(test_o)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  event  chk_ev, done_ev;
  logic [11:0] model_sr = '0;   // bench model of the shift register

  // monitor: pops the expected item and compares it against the outputs
  initial begin
    forever begin
      @(chk_ev);
      repeat (SETTLE) @(negedge clk_i);
      begin
        exp_t  e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        n_checks++;
        if ({test_o, n_o, m_o} !== e) begin
          n_fail++;
          $display("FAIL %s: got t=%b n=%b m=%h, expected t=%b n=%b m=%h",
                   tg, test_o, n_o, m_o, e.t, e.n, e.m);
        end
      end
      -> done_ev;
    end
  end

  task automatic expect_now(input logic [2:0] t, input logic [1:0] n,
                            input logic [6:0] m, input string tg);
    exp_t e;
    e.t = t; e.n = n; e.m = m;
    exp_q.push_back(e);
    tag_q.push_back(tg);
    -> chk_ev;
    @(done_ev);
  endtask

  task automatic wait_clk(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  task automatic shift_bits(input logic [11:0] w, input int cnt, input bit enabled);
    for (int i = cnt - 1; i >= 0; i--) begin
      sclk_i = 1'b0; sdata_i = w[i];
      wait_clk(HOLD);
      sclk_i = 1'b1;
      wait_clk(HOLD);
      if (enabled) model_sr = {model_sr[10:0], w[i]};
    end
    sclk_i = 1'b0;
    wait_clk(HOLD);
  endtask

  task automatic sload_pulse();
    sload_i = 1'b1;
    wait_clk(HOLD + 1);
    sload_i = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; pload_i = 1'b0; sclk_i = 1'b0; sdata_i = 1'b0; sload_i = 1'b0;
    m_i = 7'h05; n_i = 2'd2;
    wait_clk(4);
    n_checks++;
    if ({test_o, n_o, m_o} !== 12'h000) begin
      n_fail++;
      $display("FAIL R1: got %h expected 000 during reset", {test_o, n_o, m_o});
    end
    m_i = '0; n_i = '0;
    wait_clk(2);
    rst_ni = 1'b1;
    expect_now(3'b000, 2'd0, 7'h00, "R1 after release");

    m_i = 7'h2A; n_i = 2'd1;
    expect_now(3'b000, 2'd1, 7'h2A, "R2 follow pattern A");
    m_i = 7'h11; n_i = 2'd3;
    expect_now(3'b000, 2'd3, 7'h11, "R2 follow pattern B");

    pload_i = 1'b1;
    wait_clk(SETTLE);
    m_i = 7'h7F; n_i = 2'd0;
    expect_now(3'b000, 2'd3, 7'h11, "R3 captured and held");

    // full word: t=101 n=10 m=0110101
    shift_bits({3'b101, 2'b10, 7'h35}, 12, 1'b1);
    sload_i = 1'b1;
    expect_now(3'b000, 2'd3, 7'h11, "R6 no change on rising commit strobe");
    sload_i = 1'b0;
    expect_now(3'b101, 2'b10, 7'h35, "R5 R6 field order after full stream");

    sload_pulse();
    expect_now(3'b101, 2'b10, 7'h35, "R8 repeat commit keeps contents");

    shift_bits(12'h00A, 4, 1'b1);
    sload_pulse();
    expect_now(model_sr[11:9], model_sr[8:7], model_sr[6:0], "R9 short stream");

    pload_i = 1'b0;
    expect_now(3'b000, 2'd0, 7'h7F, "R7 test cleared, R2 transparent again");

    shift_bits({3'b111, 2'b01, 7'h4C}, 12, 1'b0);
    sload_pulse();
    expect_now(3'b000, 2'd0, 7'h7F, "R10 commit ignored while strobe low");

    pload_i = 1'b1;
    wait_clk(SETTLE);
    m_i = 7'h00;
    expect_now(3'b000, 2'd0, 7'h7F, "R3 capture of second parallel value");
    sload_pulse();
    expect_now(model_sr[11:9], model_sr[8:7], model_sr[6:0], "R4 shifts ignored while strobe low");

    shift_bits({3'b110, 2'b00, 7'h01}, 12, 1'b1);
    sload_pulse();
    expect_now(3'b110, 2'b00, 7'h01, "R5 second full stream");

    m_i = 7'h33; n_i = 2'd2;
    expect_now(3'b110, 2'b00, 7'h01, "R7 R3 parallel inputs cannot touch test field");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule